// File: doc/BRIEF.md
# Auto-Masking Prioritized Interrupt Controller

This block collects a set of level-sensitive interrupt lines and steers each one to the CPUs named in its routing register. The request seen for each line is the hardware input ORed with a bit that software can set. Each line also has a mask bit. A CPU raises its request output whenever at least one line is pending, unmasked and routed to it.

Each CPU services interrupts through a single claim register. Reading that register returns the lowest-numbered eligible line. The same read sets that line's mask bit, so the line cannot fire again until software clears the mask at the end of its handler. No separate end-of-interrupt register exists.

Software reaches the registers through `NUM_PORTS` independent 32-bit access ports. Each port carries a CPU index, and that index selects which CPU's view a claim or identity read sees. A port accepts a request in every cycle and applies no back-pressure. For a read, `port_rvalid` pulses one cycle after the request with the data. A write gives no response.

Top module: `irqc_top`

## Requirements
- R1: The effective request of line n is `irq_lines[n]` OR its software-trigger bit; both are level-sensitive.
- R2: Writing 1s to 0x4000+4w sets software-trigger bits and writing 1s to 0x4080+4w clears them. Line n sits in word w=n/32, bit n%32. A read at either offset returns the current bits of word w.
- R3: Writing 1s to 0x4100+4w sets mask bits and writing 1s to 0x4180+4w clears them, with the same word/bit layout as R2. A read at either offset returns the current mask word.
- R4: The routing register of line n is at 0x3000+4n, and bit c set means CPU c may receive the line. A line is never reported to, or raises the output of, a CPU whose bit is clear.
- R5: A read of 0x2004 returns {16'd1, 16'(n)}, where n is the lowest-numbered line that is pending, unmasked and routed to the port's CPU. It returns 0 when no line qualifies.
- R6: A claim read that reports line n sets line n's mask bit at the same clock edge. `cpu_irq` for that CPU drops in the following cycle if no other line qualifies.
- R7: `cpu_irq[c]` is high exactly while some line is pending, unmasked and routed to CPU c.
- R8: 0x0004 reads NUM_LINES. 0x2000 reads the CPU index on the accessing port.
- R9: After reset all mask bits are 1, all software-trigger bits are 0, and every routing register holds 1 (CPU 0).
- R10: When several ports claim in the same cycle, lower port indices claim first. A later port gets the next eligible line or 0, and no line is handed out twice. A set and a clear of the same mask bit in the same cycle leave the bit set.
- R11: Bits for lines at or above NUM_LINES, and routing registers of such lines, ignore writes and read as 0. Unmapped addresses also read 0.
- R12: `port_rvalid[p]` is high exactly one cycle after a read request on port p, and never after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Level-sensitive hardware interrupt inputs |
| port_req | input | NUM_PORTS | Access request, one bit per port |
| port_we | input | NUM_PORTS | 1 = write, 0 = read, one bit per port |
| port_addr | input | NUM_PORTS*16 | Byte address, port p in slice [p*16 +: 16] |
| port_wdata | input | NUM_PORTS*32 | Write data, port p in slice [p*32 +: 32] |
| port_cpu | input | NUM_PORTS*CPU_W | CPU index selecting the per-CPU view |
| port_rvalid | output | NUM_PORTS | Read data valid, one cycle after a read |
| port_rdata | output | NUM_PORTS*32 | Read data, port p in slice [p*32 +: 32] |
| cpu_irq | output | NUM_CPUS | Interrupt request to each CPU |

## Verification
The bench aims at the priority order and targets each failure mode directly:
- Priority encoding: when three lines are pending together, a design with an inverted priority encoder would report them highest-first.
- Auto-masking on claim: if a claim leaves the mask clear, the same line comes back on the next claim and `cpu_irq` stays high.
- Routing: a line routed away from CPU 0 must read 0 from CPU 0's view. A design that ignores routing would hand the line to the wrong CPU.
- Simultaneous claims: two ports claiming at once must receive two different lines. A broken arbitration chain would hand both ports the same line.
- Set versus clear: a set and a clear of the same mask bit in one cycle must leave the bit set. A design that orders these the other way would unmask the bit.
- Lines above the implemented count: the top half of the last mask word must read 0 after a write of all ones. Leaking these bits would show up as nonzero readback.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 10;

  localparam logic [15:0] OFF_INFO   = 16'h0004;
  localparam logic [15:0] OFF_WHOAMI = 16'h2000;
  localparam logic [15:0] OFF_CLAIM  = 16'h2004;
  localparam logic [3:0]  PAGE_ROUTE = 4'h3;
  localparam logic [8:0]  BLK_TRIG_SET = 9'h080;
  localparam logic [8:0]  BLK_TRIG_CLR = 9'h081;
  localparam logic [8:0]  BLK_MASK_SET = 9'h082;
  localparam logic [8:0]  BLK_MASK_CLR = 9'h083;

  localparam logic [15:0] CLAIM_KIND_LINE = 16'd1;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_INFO,
    RK_WHOAMI,
    RK_CLAIM,
    RK_ROUTE,
    RK_TRIG_SET,
    RK_TRIG_CLR,
    RK_MASK_SET,
    RK_MASK_CLR
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [SEL_W-1:0] sel;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t r;
    r.kind = RK_NONE;
    r.sel  = '0;
    if (a[1:0] == 2'b00) begin
      if (a == OFF_INFO)                r.kind = RK_INFO;
      else if (a == OFF_WHOAMI)         r.kind = RK_WHOAMI;
      else if (a == OFF_CLAIM)          r.kind = RK_CLAIM;
      else if (a[15:12] == PAGE_ROUTE) begin
        r.kind = RK_ROUTE;
        r.sel  = a[11:2];
      end
      else if (a[15:7] == BLK_TRIG_SET) begin
        r.kind = RK_TRIG_SET;
        r.sel  = {5'b0, a[6:2]};
      end
      else if (a[15:7] == BLK_TRIG_CLR) begin
        r.kind = RK_TRIG_CLR;
        r.sel  = {5'b0, a[6:2]};
      end
      else if (a[15:7] == BLK_MASK_SET) begin
        r.kind = RK_MASK_SET;
        r.sel  = {5'b0, a[6:2]};
      end
      else if (a[15:7] == BLK_MASK_CLR) begin
        r.kind = RK_MASK_CLR;
        r.sel  = {5'b0, a[6:2]};
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/irqc_lowest_first.sv
module irqc_lowest_first #(
  parameter int W     = 48,
  parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [W-1:0]     onehot
);
  // isolate the least significant set bit
  assign onehot = vec & (~vec + W'(1));
  assign found  = |vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_claim_arb.sv
module irqc_claim_arb #(
  parameter int NUM_LINES = 48,
  parameter int NUM_CPUS  = 4,
  parameter int NUM_PORTS = 2,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0]                avail,
  input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  route,
  input  logic [NUM_PORTS-1:0]                claim_rd,
  input  logic [NUM_PORTS-1:0][CPU_W-1:0]     claim_cpu,
  output logic [NUM_PORTS-1:0]                claim_found,
  output logic [NUM_PORTS-1:0][IDX_W-1:0]     claim_idx,
  output logic [NUM_LINES-1:0]                claim_bits
);
  // each port sees what earlier ports left over
  logic [NUM_LINES-1:0] chain  [NUM_PORTS+1];
  logic [NUM_LINES-1:0] won    [NUM_PORTS];

  assign chain[0] = avail;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [NUM_LINES-1:0] sel_route;
    logic [NUM_LINES-1:0] elig;
    logic [NUM_LINES-1:0] oh;

    always_comb begin
      sel_route = '0;
      for (int c = 0; c < NUM_CPUS; c++) begin
        if (claim_cpu[p] == CPU_W'(c)) sel_route = route[c];
      end
    end

    assign elig = claim_rd[p] ? (chain[p] & sel_route) : '0;

    irqc_lowest_first #(.W(NUM_LINES), .IDX_W(IDX_W)) u_enc (
      .vec    (elig),
      .found  (claim_found[p]),
      .idx    (claim_idx[p]),
      .onehot (oh)
    );

    assign won[p]       = oh;
    assign chain[p + 1] = chain[p] & ~oh;
  end

  always_comb begin
    claim_bits = '0;
    for (int p = 0; p < NUM_PORTS; p++) claim_bits = claim_bits | won[p];
  end
endmodule

// File: rtl/irqc_line_state.sv
module irqc_line_state
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 48,
  parameter int NUM_CPUS  = 4,
  parameter int NUM_PORTS = 2,
  localparam int NUM_WORDS = (NUM_LINES + 31) / 32,
  localparam int PAD_W     = NUM_WORDS * 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_PORTS-1:0]                 wr_trig_set,
  input  logic [NUM_PORTS-1:0]                 wr_trig_clr,
  input  logic [NUM_PORTS-1:0]                 wr_mask_set,
  input  logic [NUM_PORTS-1:0]                 wr_mask_clr,
  input  logic [NUM_PORTS-1:0]                 wr_route,
  input  logic [NUM_PORTS-1:0][SEL_W-1:0]      wr_sel,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]     wr_data,
  input  logic [NUM_LINES-1:0]                 claim_bits,
  output logic [NUM_LINES-1:0]                 trig_q,
  output logic [NUM_LINES-1:0]                 mask_q,
  output logic [NUM_LINES-1:0][NUM_CPUS-1:0]   route_q
);
  logic [NUM_LINES-1:0] tset, tclr, mset, mclr;
  logic [NUM_LINES-1:0][NUM_CPUS-1:0] route_d;

  // spread each port's word write over the line vector
  always_comb begin
    logic [PAD_W-1:0] spread;
    tset = '0; tclr = '0; mset = '0; mclr = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      spread = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (wr_sel[p] == SEL_W'(w)) spread[w*32 +: 32] = wr_data[p];
      end
      if (wr_trig_set[p]) tset = tset | spread[NUM_LINES-1:0];
      if (wr_trig_clr[p]) tclr = tclr | spread[NUM_LINES-1:0];
      if (wr_mask_set[p]) mset = mset | spread[NUM_LINES-1:0];
      if (wr_mask_clr[p]) mclr = mclr | spread[NUM_LINES-1:0];
    end
  end

  // lower port index wins a same-cycle routing write
  always_comb begin
    route_d = route_q;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (wr_route[p]) begin
        for (int n = 0; n < NUM_LINES; n++) begin
          if (wr_sel[p] == SEL_W'(n)) route_d[n] = wr_data[p][NUM_CPUS-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= '0;
      mask_q <= '1;
      for (int n = 0; n < NUM_LINES; n++) route_q[n] <= NUM_CPUS'(1);
    end else begin
      trig_q  <= (trig_q & ~tclr) | tset;
      mask_q  <= (mask_q & ~mclr) | mset | claim_bits;
      route_q <= route_d;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 48,
  parameter int NUM_CPUS  = 4,
  parameter int NUM_PORTS = 2,
  localparam int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int NUM_WORDS = (NUM_LINES + 31) / 32,
  localparam int PAD_W     = NUM_WORDS * 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LINES-1:0]          irq_lines,
  input  logic [NUM_PORTS-1:0]          port_req,
  input  logic [NUM_PORTS-1:0]          port_we,
  input  logic [NUM_PORTS*ADDR_W-1:0]   port_addr,
  input  logic [NUM_PORTS*DATA_W-1:0]   port_wdata,
  input  logic [NUM_PORTS*CPU_W-1:0]    port_cpu,
  output logic [NUM_PORTS-1:0]          port_rvalid,
  output logic [NUM_PORTS*DATA_W-1:0]   port_rdata,
  output logic [NUM_CPUS-1:0]           cpu_irq
);
  logic [NUM_LINES-1:0]                trig_q, mask_q, pend, avail, claim_bits;
  logic [NUM_LINES-1:0][NUM_CPUS-1:0]  route_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  route_by_cpu;
  logic [NUM_PORTS-1:0]                wr_trig_set, wr_trig_clr, wr_mask_set, wr_mask_clr, wr_route;
  logic [NUM_PORTS-1:0]                claim_rd, claim_found;
  logic [NUM_PORTS-1:0][IDX_W-1:0]     claim_idx;
  logic [NUM_PORTS-1:0][SEL_W-1:0]     sel_v;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    wdata_v;
  logic [NUM_PORTS-1:0][CPU_W-1:0]     cpu_v;
  logic [NUM_PORTS-1:0]                rvalid_q;
  logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata_q;
  logic [PAD_W-1:0]                    trig_pad, mask_pad;

  assign pend     = irq_lines | trig_q;
  assign avail    = pend & ~mask_q;
  assign trig_pad = PAD_W'(trig_q);
  assign mask_pad = PAD_W'(mask_q);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      assign route_by_cpu[c][n] = route_q[n][c];
    end
    assign cpu_irq[c] = |(avail & route_by_cpu[c]);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    reg_sel_t    dec;
    logic        rd_go, wr_go;
    logic [DATA_W-1:0] rd_val;

    assign dec        = decode_addr(port_addr[p*ADDR_W +: ADDR_W]);
    assign rd_go      = port_req[p] && !port_we[p];
    assign wr_go      = port_req[p] && port_we[p];
    assign sel_v[p]   = dec.sel;
    assign wdata_v[p] = port_wdata[p*DATA_W +: DATA_W];
    assign cpu_v[p]   = port_cpu[p*CPU_W +: CPU_W];

    assign wr_trig_set[p] = wr_go && (dec.kind == RK_TRIG_SET);
    assign wr_trig_clr[p] = wr_go && (dec.kind == RK_TRIG_CLR);
    assign wr_mask_set[p] = wr_go && (dec.kind == RK_MASK_SET);
    assign wr_mask_clr[p] = wr_go && (dec.kind == RK_MASK_CLR);
    assign wr_route[p]    = wr_go && (dec.kind == RK_ROUTE);
    assign claim_rd[p]    = rd_go && (dec.kind == RK_CLAIM);

    always_comb begin
      rd_val = '0;
      unique case (dec.kind)
        RK_INFO:   rd_val = DATA_W'(NUM_LINES);
        RK_WHOAMI: rd_val = DATA_W'(cpu_v[p]);
        RK_CLAIM:  rd_val = claim_found[p] ? {CLAIM_KIND_LINE, 16'(claim_idx[p])} : '0;
        RK_ROUTE: begin
          for (int n = 0; n < NUM_LINES; n++)
            if (dec.sel == SEL_W'(n)) rd_val = DATA_W'(route_q[n]);
        end
        RK_TRIG_SET, RK_TRIG_CLR: begin
          for (int w = 0; w < NUM_WORDS; w++)
            if (dec.sel == SEL_W'(w)) rd_val = trig_pad[w*32 +: 32];
        end
        RK_MASK_SET, RK_MASK_CLR: begin
          for (int w = 0; w < NUM_WORDS; w++)
            if (dec.sel == SEL_W'(w)) rd_val = mask_pad[w*32 +: 32];
        end
        default:   rd_val = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rvalid_q[p] <= 1'b0;
        rdata_q[p]  <= '0;
      end else begin
        rvalid_q[p] <= rd_go;
        if (rd_go) rdata_q[p] <= rd_val;
      end
    end

    assign port_rvalid[p]                = rvalid_q[p];
    assign port_rdata[p*DATA_W +: DATA_W] = rdata_q[p];
  end

  irqc_claim_arb #(
    .NUM_LINES (NUM_LINES),
    .NUM_CPUS  (NUM_CPUS),
    .NUM_PORTS (NUM_PORTS)
  ) u_arb (
    .avail       (avail),
    .route       (route_by_cpu),
    .claim_rd    (claim_rd),
    .claim_cpu   (cpu_v),
    .claim_found (claim_found),
    .claim_idx   (claim_idx),
    .claim_bits  (claim_bits)
  );

  irqc_line_state #(
    .NUM_LINES (NUM_LINES),
    .NUM_CPUS  (NUM_CPUS),
    .NUM_PORTS (NUM_PORTS)
  ) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_trig_set (wr_trig_set),
    .wr_trig_clr (wr_trig_clr),
    .wr_mask_set (wr_mask_set),
    .wr_mask_clr (wr_mask_clr),
    .wr_route    (wr_route),
    .wr_sel      (sel_v),
    .wr_data     (wdata_v),
    .claim_bits  (claim_bits),
    .trig_q      (trig_q),
    .mask_q      (mask_q),
    .route_q     (route_q)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_LINES = 48,
  parameter int NUM_CPUS  = 4,
  parameter int NUM_PORTS = 2,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_CPUS-1:0]             cpu_irq,
  input logic [NUM_LINES-1:0]            mask_q,
  input logic [NUM_LINES-1:0]            trig_q,
  input logic [NUM_LINES-1:0]            claim_bits,
  input logic [NUM_PORTS-1:0]            claim_found,
  input logic [NUM_PORTS-1:0][IDX_W-1:0] claim_idx,
  input logic [NUM_PORTS-1:0]            port_req,
  input logic [NUM_PORTS-1:0]            port_we,
  input logic [NUM_PORTS-1:0]            port_rvalid
);
  logic dup_claim;

  always_comb begin
    dup_claim = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++)
      for (int j = i + 1; j < NUM_PORTS; j++)
        if (claim_found[i] && claim_found[j] && claim_idx[i] == claim_idx[j])
          dup_claim = 1'b1;
  end

  // R6: a claimed line is masked after the edge
  a_r6_claim_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_bits != '0) |=> ((mask_q & $past(claim_bits)) == $past(claim_bits)));

  // R10: no line handed to two ports
  a_r10_distinct_claims: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_claim);

  // R7: nothing can request when every line is masked
  a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> (cpu_irq == '0));

  // R9: state right after reset
  a_r9_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> ((&mask_q) && (trig_q == '0)));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
    // R12: response one cycle after a read only
    a_r12_rvalid_timing: assert property (@(posedge clk) disable iff (!rst_n)
      port_rvalid[p] == $past(port_req[p] && !port_we[p] && rst_n));
  end
endmodule

bind irqc_top irqc_checker #(
  .NUM_LINES (NUM_LINES),
  .NUM_CPUS  (NUM_CPUS),
  .NUM_PORTS (NUM_PORTS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_irq     (cpu_irq),
  .mask_q      (mask_q),
  .trig_q      (trig_q),
  .claim_bits  (claim_bits),
  .claim_found (claim_found),
  .claim_idx   (claim_idx),
  .port_req    (port_req),
  .port_we     (port_we),
  .port_rvalid (port_rvalid)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int L  = 48;
  localparam int C  = 4;
  localparam int P  = 2;
  localparam int CW = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [L-1:0]    irq_lines = '0;
  logic [P-1:0]    port_req = '0;
  logic [P-1:0]    port_we = '0;
  logic [P*16-1:0] port_addr = '0;
  logic [P*32-1:0] port_wdata = '0;
  logic [P*CW-1:0] port_cpu = '0;
  logic [P-1:0]    port_rvalid;
  logic [P*32-1:0] port_rdata;
  logic [C-1:0]    cpu_irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t q0[$];
  exp_t q1[$];

  always #2 clk = ~clk;

  irqc_top #(.NUM_LINES(L), .NUM_CPUS(C), .NUM_PORTS(P)) u_dut (
    .clk, .rst_n, .irq_lines, .port_req, .port_we, .port_addr,
    .port_wdata, .port_cpu, .port_rvalid, .port_rdata, .cpu_irq
  );

  task automatic set_port(int p, logic we, logic [1:0] cpu, logic [15:0] addr, logic [31:0] data);
    port_req[p]            = 1'b1;
    port_we[p]             = we;
    port_cpu[p*CW +: CW]   = cpu;
    port_addr[p*16 +: 16]  = addr;
    port_wdata[p*32 +: 32] = data;
  endtask

  task automatic push(int p, logic [31:0] v, string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    if (p == 0) q0.push_back(e);
    else        q1.push_back(e);
  endtask

  task automatic wr(logic [15:0] addr, logic [31:0] data);
    @(negedge clk);
    set_port(0, 1'b1, 2'd0, addr, data);
    @(negedge clk);
    port_req = '0;
  endtask

  task automatic rd(int p, logic [1:0] cpu, logic [15:0] addr, logic [31:0] exp, string tag);
    @(negedge clk);
    set_port(p, 1'b0, cpu, addr, 32'h0);
    push(p, exp, tag);
    @(negedge clk);
    port_req = '0;
  endtask

  task automatic rd2(logic [1:0] c0, logic [15:0] a0, logic [31:0] e0,
                     logic [1:0] c1, logic [15:0] a1, logic [31:0] e1, string tag);
    @(negedge clk);
    set_port(0, 1'b0, c0, a0, 32'h0);
    set_port(1, 1'b0, c1, a1, 32'h0);
    push(0, e0, tag);
    push(1, e1, tag);
    @(negedge clk);
    port_req = '0;
  endtask

  task automatic wr2(logic [15:0] a0, logic [31:0] d0, logic [15:0] a1, logic [31:0] d1);
    @(negedge clk);
    set_port(0, 1'b1, 2'd0, a0, d0);
    set_port(1, 1'b1, 2'd0, a1, d1);
    @(negedge clk);
    port_req = '0;
  endtask

  task automatic chk_irq(logic [C-1:0] exp, string tag);
    checks++;
    if (cpu_irq !== exp) begin
      errors++;
      $display("FAIL %s cpu_irq actual=%b expected=%b", tag, cpu_irq, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < P; p++) begin
        if (port_rvalid[p]) begin
          exp_t e;
          checks++;
          if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
            errors++;
            $display("FAIL R12 port %0d unexpected rvalid actual=1 expected=0", p);
          end else begin
            e = (p == 0) ? q0.pop_front() : q1.pop_front();
            if (port_rdata[p*32 +: 32] !== e.val) begin
              errors++;
              $display("FAIL %s port %0d actual=%h expected=%h", e.tag, p,
                       port_rdata[p*32 +: 32], e.val);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state, R11 unimplemented upper bits
    chk_irq(4'b0000, "R9");
    rd(0, 0, 16'h4100, 32'hFFFF_FFFF, "R9 mask word0");
    rd(0, 0, 16'h4104, 32'h0000_FFFF, "R11 mask word1");
    rd(0, 0, 16'h4000, 32'h0, "R9 trig word0");
    rd(0, 0, 16'h3014, 32'h1, "R9 route line5");

    // R8 identity registers
    rd(0, 0, 16'h0004, 32'd48, "R8 info");
    rd(1, 3, 16'h2000, 32'd3, "R8 whoami");

    // R1/R7 hw line pending but masked, then unmasked
    @(negedge clk);
    irq_lines[10] = 1'b1;
    @(negedge clk);
    chk_irq(4'b0000, "R7 masked");
    wr(16'h4180, 32'h0000_0400);
    chk_irq(4'b0001, "R7 unmasked");

    // R5/R6 claim and auto-mask
    rd(0, 0, 16'h2004, 32'h0001_000A, "R5 claim line10");
    chk_irq(4'b0000, "R6 drop");
    rd(0, 0, 16'h4100, 32'hFFFF_FFFF, "R6 mask after claim");

    // R5 priority, R1 software trigger, R3 word1 clear
    wr(16'h4180, 32'h0010_0008);
    wr(16'h4184, 32'h0000_0100);
    wr(16'h4000, 32'h0010_0000);
    @(negedge clk);
    irq_lines[3]  = 1'b1;
    irq_lines[40] = 1'b1;
    @(negedge clk);
    chk_irq(4'b0001, "R1");
    rd(0, 0, 16'h2004, 32'h0001_0003, "R5 first");
    rd(0, 0, 16'h2004, 32'h0001_0014, "R5 second");
    rd(0, 0, 16'h2004, 32'h0001_0028, "R5 third");
    rd(0, 0, 16'h2004, 32'h0, "R5 empty");
    chk_irq(4'b0000, "R6 all claimed");

    // R4 routing
    wr(16'h3050, 32'h4);
    wr(16'h4180, 32'h0010_0000);
    chk_irq(4'b0100, "R4 irq cpu2");
    rd(0, 0, 16'h2004, 32'h0, "R4 cpu0 blind");
    rd(0, 2, 16'h2004, 32'h0001_0014, "R4 cpu2 claim");
    rd(0, 0, 16'h3050, 32'h4, "R4 route readback");

    // R2 software trigger clear
    wr(16'h4080, 32'h0010_0000);
    rd(0, 0, 16'h4000, 32'h0, "R2 trig cleared");
    wr(16'h4180, 32'h0010_0000);
    chk_irq(4'b0000, "R2 no pending");

    // R10 simultaneous claims
    wr(16'h300C, 32'h3);
    wr(16'h3028, 32'h3);
    wr(16'h4180, 32'h0000_0408);
    chk_irq(4'b0011, "R10 both cpus");
    rd2(1, 16'h2004, 32'h0001_0003, 0, 16'h2004, 32'h0001_000A, "R10 dual claim");
    chk_irq(4'b0000, "R10 after claims");
    wr2(16'h4180, 32'h0000_0020, 16'h4100, 32'h0000_0020);
    rd(0, 0, 16'h4100, 32'hFFEF_FFFF, "R10 set beats clear");

    // R11 bits and lines beyond the implemented count
    wr(16'h4104, 32'hFFFF_0000);
    rd(0, 0, 16'h4104, 32'h0000_FFFF, "R11 upper set ignored");
    wr(16'h4184, 32'hFFFF_FFFF);
    rd(0, 0, 16'h4184, 32'h0, "R3 word1 cleared");
    chk_irq(4'b0001, "R3 line40 live");
    wr(16'h30C8, 32'h2);
    rd(0, 0, 16'h30C8, 32'h0, "R11 route line50");
    rd(0, 0, 16'h4108, 32'h0, "R11 word2");
    rd(1, 1, 16'h1000, 32'h0, "R11 unmapped");

    repeat (3) @(negedge clk);
    checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      errors++;
      $display("FAIL R12 missing responses actual=%0d expected=0", q0.size() + q1.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule